// File: doc/BRIEF.md
# Auto-Reload Single-Channel DMA Engine

This block is one DMA channel. It copies a run of units from a source address to a destination address through a simple memory port. A unit is one, two or four bytes wide. Software programs start addresses, per-side address modes and a control word through a small register port. It then writes the run bit of the trigger register. Every unit is one read cycle followed by one write cycle, and the write carries the data that came back from the read.

The programmed start addresses and count are shadow values. While a transfer runs, software may overwrite them to queue the next buffer, and the active pointers are not disturbed. At terminal count the engine pulses its interrupt for one cycle. If the no-reload bit of the live control word is clear, the engine then copies the shadow set into the active set and carries on. If the bit is set, the engine halts. Software can also ask for an abort, which the engine honours at the next unit boundary.

Top module: `dma_reload_channel`

## Requirements
- R1: After reset every register reads 0, run reads 0, `irq` is 0 and `memReq` is 0.
- R2: A side's mode field (byte offsets 0x04 source, 0x0C destination) works as follows. Bit 0 = 0 steps that side's address by the unit size in bytes (1, 2 or 4) after each unit, and bit 0 = 1 holds the address. Bit 1 is driven on `memBus` during that side's access.
- R3: Each unit is a read at the current source address (`memReq`=1, `memWe`=0). In the next cycle comes a write at the current destination address carrying the read data. `memSize` gives the unit code, which is control bits 21:20 (0 byte, 1 halfword, 2 word).
- R4: Control word (offset 0x10) bits 19:0 hold the shadow unit count. The status register (offset 0x14) reads the active remaining count. It is non-zero while a transfer is loaded and drops by one per unit.
- R5: Writes to the start addresses (0x00 source, 0x08 destination) or to the control word during a transfer change only the shadow values. The active addresses and count are unchanged until the next reload.
- R6: With control bit 23 set, each unit's read waits until `hwReq` is 1. With the bit clear, units run back to back.
- R7: With control bit 24 set, `irq` is high for exactly one cycle after the write of the final unit of every buffer, whatever the no-reload setting.
- R8: With control bit 22 clear at terminal count, the shadow addresses and count are loaded and the transfer continues. The first unit of the new buffer is written exactly three cycles after the last unit of the old one.
- R9: With control bit 22 set at terminal count, the channel halts and trigger bit 0 (run, offset 0x20) reads 0.
- R10: Writing 1 to trigger bit 1 during a transfer stops the channel at the next unit boundary. Run and abort then read 0, no further memory access takes place, and the status keeps the remaining count.
- R11: A start (trigger bit 0 written 1) with a shadow count of zero is ignored. Run stays 0 and no memory access is made.
- R12: Offsets 0x18 and 0x1C read back the current source and destination addresses at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | RA_W (6) | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| hwReq | input | 1 | Peripheral request for the hardware-triggered mode |
| memReq | output | 1 | Memory access valid this cycle |
| memWe | output | 1 | 1 for a write, 0 for a read |
| memAddr | output | ADDR_W (32) | Memory byte address |
| memSize | output | 2 | Unit size code of the access |
| memBus | output | 1 | Bus select of the side being accessed |
| memWdata | output | DATA_W (32) | Write data, equal to the read data of the previous cycle |
| memRdata | input | DATA_W (32) | Read data, valid the cycle after a read |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory returns read data in the cycle after a read, and that a running transfer never has a count of zero. The second holds because a start or a reload with an empty shadow count is refused. They also assume that software does not write start and abort together with conflicting intent. The stimulus writes registers only between clock edges, programs counts from 1 to 10, and uses only the three legal unit codes. `hwReq` comes either from a random per-cycle bit or from directed levels. The directed levels stall the engine at chosen unit boundaries for the reload, abort and isolation checks.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_TERM
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadActive;
    logic stepUnit;
    logic clearRun;
    logic rdPhase;
    logic wrPhase;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic startReq;
    logic abortPend;
    logic hwTrig;
    logic lastUnit;
    logic cntNz;
    logic shadowCntNz;
    logic noReload;
    logic irqEn;
  } dpStatus_t;

  // register word indices (byte offset / 4)
  localparam logic [3:0] REG_SRC_START = 4'd0;
  localparam logic [3:0] REG_SRC_MODE  = 4'd1;
  localparam logic [3:0] REG_DST_START = 4'd2;
  localparam logic [3:0] REG_DST_MODE  = 4'd3;
  localparam logic [3:0] REG_CTRL      = 4'd4;
  localparam logic [3:0] REG_STATUS    = 4'd5;
  localparam logic [3:0] REG_CUR_SRC   = 4'd6;
  localparam logic [3:0] REG_CUR_DST   = 4'd7;
  localparam logic [3:0] REG_TRIG      = 4'd8;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  st,
  input  logic       hwReq,
  output ctlStrobe_t stb,
  output logic       irq
);

  chanState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (st.startReq && st.shadowCntNz) begin
          stb.loadActive = 1'b1;
          nxt = ST_RD;
        end
      end
      ST_RD: begin
        if (st.abortPend) begin
          stb.clearRun = 1'b1;
          nxt = ST_IDLE;
        end else if (!st.hwTrig || hwReq) begin
          stb.rdPhase = 1'b1;
          nxt = ST_WR;
        end
      end
      ST_WR: begin
        stb.wrPhase  = 1'b1;
        stb.stepUnit = 1'b1;
        if (st.lastUnit) begin
          nxt = ST_TERM;
        end else if (st.abortPend) begin
          stb.clearRun = 1'b1;
          nxt = ST_IDLE;
        end else begin
          nxt = ST_RD;
        end
      end
      ST_TERM: begin
        if (st.abortPend || st.noReload || !st.shadowCntNz) begin
          stb.clearRun = 1'b1;
          nxt = ST_IDLE;
        end else begin
          stb.loadActive = 1'b1;
          nxt = ST_RD;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // completion pulse lives in the single terminal cycle
  assign irq = (state == ST_TERM) && st.irqEn;

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  p_wr_after_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrPhase |-> $past(stb.rdPhase));

  p_active_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD || state == ST_WR) |-> st.cntNz);

endmodule

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20,
  parameter int RA_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  ctlStrobe_t        stb,
  output dpStatus_t         st,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic              memBus,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int UNIT_LSB = CNT_W;
  localparam int NORL_BIT = CNT_W + 2;
  localparam int HWT_BIT  = CNT_W + 3;
  localparam int IRQ_BIT  = CNT_W + 4;
  localparam int CTRL_W   = CNT_W + 5;

  logic [ADDR_W-1:0] srcStart, dstStart, curSrc, curDst, stepBytes;
  logic [1:0]        srcMode, dstMode, actSrcMode, actDstMode, actUnit;
  logic [CTRL_W-1:0] ctrlReg;
  logic [CNT_W-1:0]  curCnt;
  logic              actHwTrig, runFlag, abortPend;
  logic [3:0]        wordIdx;

  assign wordIdx = regAddr[RA_W-1:2];

  // shadow (software-visible) registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcStart <= '0;
      dstStart <= '0;
      srcMode  <= '0;
      dstMode  <= '0;
      ctrlReg  <= '0;
    end else if (regWe) begin
      case (wordIdx)
        REG_SRC_START: srcStart <= regWdata[ADDR_W-1:0];
        REG_SRC_MODE:  srcMode  <= regWdata[1:0];
        REG_DST_START: dstStart <= regWdata[ADDR_W-1:0];
        REG_DST_MODE:  dstMode  <= regWdata[1:0];
        REG_CTRL:      ctrlReg  <= regWdata[CTRL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (actUnit)
      2'd0:    stepBytes = ADDR_W'(1);
      2'd1:    stepBytes = ADDR_W'(2);
      default: stepBytes = ADDR_W'(4);
    endcase
  end

  // active set: changes only at load and at each unit step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc     <= '0;
      curDst     <= '0;
      curCnt     <= '0;
      actUnit    <= '0;
      actSrcMode <= '0;
      actDstMode <= '0;
      actHwTrig  <= 1'b0;
    end else if (stb.loadActive) begin
      curSrc     <= srcStart;
      curDst     <= dstStart;
      curCnt     <= ctrlReg[CNT_W-1:0];
      actUnit    <= ctrlReg[UNIT_LSB+1:UNIT_LSB];
      actSrcMode <= srcMode;
      actDstMode <= dstMode;
      actHwTrig  <= ctrlReg[HWT_BIT];
    end else if (stb.stepUnit) begin
      curCnt <= curCnt - CNT_W'(1);
      if (!actSrcMode[0]) curSrc <= curSrc + stepBytes;
      if (!actDstMode[0]) curDst <= curDst + stepBytes;
    end
  end

  logic trigWr;
  assign trigWr = regWe && (wordIdx == REG_TRIG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runFlag   <= 1'b0;
      abortPend <= 1'b0;
    end else begin
      if (stb.loadActive)    runFlag <= 1'b1;
      else if (stb.clearRun) runFlag <= 1'b0;
      if (stb.clearRun)                          abortPend <= 1'b0;
      else if (trigWr && regWdata[1] && runFlag) abortPend <= 1'b1;
    end
  end

  always_comb begin
    st.startReq    = trigWr && regWdata[0];
    st.abortPend   = abortPend;
    st.hwTrig      = actHwTrig;
    st.lastUnit    = (curCnt == CNT_W'(1));
    st.cntNz       = (curCnt != '0);
    st.shadowCntNz = (ctrlReg[CNT_W-1:0] != '0);
    st.noReload    = ctrlReg[NORL_BIT];
    st.irqEn       = ctrlReg[IRQ_BIT];
  end

  always_comb begin
    case (wordIdx)
      REG_SRC_START: regRdata = 32'(srcStart);
      REG_SRC_MODE:  regRdata = 32'(srcMode);
      REG_DST_START: regRdata = 32'(dstStart);
      REG_DST_MODE:  regRdata = 32'(dstMode);
      REG_CTRL:      regRdata = 32'(ctrlReg);
      REG_STATUS:    regRdata = 32'(curCnt);
      REG_CUR_SRC:   regRdata = 32'(curSrc);
      REG_CUR_DST:   regRdata = 32'(curDst);
      REG_TRIG:      regRdata = {30'd0, abortPend, runFlag};
      default:       regRdata = 32'd0;
    endcase
  end

  assign memReq   = stb.rdPhase | stb.wrPhase;
  assign memWe    = stb.wrPhase;
  assign memAddr  = stb.wrPhase ? curDst : curSrc;
  assign memBus   = stb.wrPhase ? actDstMode[1] : actSrcMode[1];
  assign memSize  = actUnit;
  assign memWdata = memRdata;

  // shadow writes never move the active pointers between steps
  p_shadow_isolation_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadActive && !stb.stepUnit) |=> ($stable(curSrc) && $stable(curDst) && $stable(curCnt)));

  p_no_access_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!runFlag && !$past(runFlag)) |-> !memReq);

endmodule

// File: rtl/dma_reload_channel.sv
module dma_reload_channel
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20,
  parameter int RA_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [RA_W-1:0]   regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              hwReq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic              memBus,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq
);

  ctlStrobe_t stb;
  dpStatus_t  st;

  dma_chan_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .st    (st),
    .hwReq (hwReq),
    .stb   (stb),
    .irq   (irq)
  );

  dma_chan_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .RA_W   (RA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .stb      (stb),
    .st       (st),
    .memReq   (memReq),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memSize  (memSize),
    .memBus   (memBus),
    .memWdata (memWdata),
    .memRdata (memRdata)
  );

  p_hw_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && st.hwTrig) |-> hwReq);

endmodule

// File: tb/tb_dma_reload_channel.sv
module tb_dma_reload_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        hwReq;
  logic        memReq, memWe, memBus, irq;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic [1:0]  memSize;

  logic hwForce = 1'b0;
  logic randMode = 1'b0;
  logic randBit = 1'b0;
  assign hwReq = randMode ? randBit : hwForce;

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  dma_reload_channel dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .hwReq(hwReq),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memBus(memBus), .memWdata(memWdata), .memRdata(memRdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] expData(input logic [31:0] a);
    return (a * 32'd2654435761) ^ 32'h5A3C_0000;
  endfunction

  function automatic logic [31:0] stepOf(input int unit);
    return 32'd1 << unit;
  endfunction

  // memory model and monitors
  logic [31:0] wrAddr [512];
  logic [31:0] wrData [512];
  logic        wrBus  [512];
  logic [1:0]  wrSize [512];
  int          wrCyc  [512];
  int wrCount = 0, rdCount = 0, irqCount = 0;

  always @(posedge clk) begin
    cycle <= cycle + 1;
    if (memReq && !memWe) begin
      memRdata <= expData(memAddr);
      rdCount  <= rdCount + 1;
    end
    if (memReq && memWe) begin
      wrAddr[wrCount[8:0]] <= memAddr;
      wrData[wrCount[8:0]] <= memWdata;
      wrBus[wrCount[8:0]]  <= memBus;
      wrSize[wrCount[8:0]] <= memSize;
      wrCyc[wrCount[8:0]]  <= cycle;
      wrCount <= wrCount + 1;
    end
    if (irq) irqCount <= irqCount + 1;
  end

  always @(negedge clk) randBit <= 1'($urandom % 2);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      regRead(6'h20, v);
      if (v[0] == 1'b0) begin ok = 1; break; end
    end
  endtask

  function automatic logic [31:0] ctrlWord(input int cnt, input int unit,
      input bit noRl, input bit hw, input bit ie);
    return 32'(cnt) | (32'(unit) << 20) | (32'(noRl) << 22) |
           (32'(hw) << 23) | (32'(ie) << 24);
  endfunction

  task automatic runRandom(input int idx);
    int unit, cnt, base, irqBase;
    logic [1:0] sm, dm;
    bit hw, ok, seqOk;
    logic [31:0] src, dst, st, v, ea, ed;
    unit = $urandom % 3; cnt = 1 + $urandom % 6;
    sm = 2'($urandom); dm = 2'($urandom); hw = 1'($urandom);
    src = $urandom & 32'h00FF_FFF0; dst = $urandom & 32'h00FF_FFF0;
    st = stepOf(unit);
    base = wrCount; irqBase = irqCount;
    regWrite(6'h00, src); regWrite(6'h04, 32'(sm));
    regWrite(6'h08, dst); regWrite(6'h0C, 32'(dm));
    regWrite(6'h10, ctrlWord(cnt, unit, 1, hw, 1));
    randMode = hw;
    regWrite(6'h20, 32'h1);
    waitIdle(ok);
    randMode = 1'b0;
    check(ok, "R9", "random run halts", 32'(ok), 32'd1);
    check(wrCount - base == cnt, "R4", "unit count", 32'(wrCount - base), 32'(cnt));
    seqOk = 1; ea = 0; ed = 0;
    for (int k = 0; k < cnt && k < wrCount - base; k++) begin
      ea = dst + (dm[0] ? 32'd0 : 32'(k) * st);
      ed = expData(src + (sm[0] ? 32'd0 : 32'(k) * st));
      if (wrAddr[(base + k) % 512] !== ea || wrData[(base + k) % 512] !== ed ||
          wrBus[(base + k) % 512] !== dm[1] || wrSize[(base + k) % 512] !== 2'(unit))
        seqOk = 0;
    end
    check(seqOk, "R2", $sformatf("run %0d address/data/bus sequence", idx),
          wrAddr[(base + cnt - 1) % 512], ea);
    check(seqOk, "R3", $sformatf("run %0d write data follows read", idx),
          wrData[(base + cnt - 1) % 512], ed);
    check(irqCount - irqBase == 1, "R7", "one irq per buffer",
          32'(irqCount - irqBase), 32'd1);
    regRead(6'h14, v);
    check(v == 0, "R4", "status zero at end", v, 32'd0);
    regRead(6'h18, v);
    ea = src + (sm[0] ? 32'd0 : 32'(cnt) * st);
    check(v == ea, "R12", "current source readback", v, ea);
  endtask

  bit finished = 0;

  initial begin
    while (cycle < 100000 && !finished) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cycle);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, irqBase, rdBase;
    bit ok, seqOk;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a <= 8; a++) begin
      regRead(6'(a * 4), v);
      check(v == 0, "R1", $sformatf("reset value reg %0d", a), v, 32'd0);
    end
    check(!irq && !memReq, "R1", "irq/memReq idle", {30'd0, irq, memReq}, 32'd0);

    // R11 start with zero count
    rdBase = rdCount;
    regWrite(6'h10, ctrlWord(0, 2, 1, 0, 1));
    regWrite(6'h20, 32'h1);
    repeat (4) @(negedge clk);
    regRead(6'h20, v);
    check(v == 0, "R11", "run stays 0 on empty start", v, 32'd0);
    check(rdCount == rdBase, "R11", "no access on empty start", 32'(rdCount), 32'(rdBase));

    // R5/R6/R8 reload chain
    base = wrCount; irqBase = irqCount;
    hwForce = 1'b0;
    regWrite(6'h00, 32'h1000); regWrite(6'h04, 32'h0);
    regWrite(6'h08, 32'h2000); regWrite(6'h0C, 32'h2);
    regWrite(6'h10, ctrlWord(4, 2, 0, 1, 1));
    regWrite(6'h20, 32'h1);
    repeat (6) @(negedge clk);
    check(wrCount == base, "R6", "stall while hwReq low", 32'(wrCount - base), 32'd0);
    regRead(6'h14, v);
    check(v == 4, "R4", "status non-zero when loaded", v, 32'd4);
    regWrite(6'h00, 32'h3000); regWrite(6'h08, 32'h4000); regWrite(6'h0C, 32'h1);
    regWrite(6'h10, ctrlWord(3, 0, 0, 1, 1));
    regRead(6'h18, v);
    check(v == 32'h1000, "R5", "active source unchanged", v, 32'h1000);
    regRead(6'h14, v);
    check(v == 4, "R5", "active count unchanged", v, 32'd4);
    hwForce = 1'b1;
    while (wrCount < base + 5) @(negedge clk);
    hwForce = 1'b0;
    check(wrCyc[(base + 4) % 512] - wrCyc[(base + 3) % 512] == 3, "R8", "reload gap",
          32'(wrCyc[(base + 4) % 512] - wrCyc[(base + 3) % 512]), 32'd3);
    check(wrBus[(base + 3) % 512] == 1'b1, "R2", "destination bus select",
          32'(wrBus[(base + 3) % 512]), 32'd1);
    regRead(6'h18, v);
    check(v == 32'h3001, "R8", "reloaded source stepped", v, 32'h3001);
    regRead(6'h1C, v);
    check(v == 32'h4000, "R2", "held destination", v, 32'h4000);
    regWrite(6'h10, ctrlWord(3, 0, 1, 1, 1));
    hwForce = 1'b1;
    waitIdle(ok);
    hwForce = 1'b0;
    check(ok, "R9", "halt after no-reload", 32'(ok), 32'd1);
    check(wrCount - base == 7, "R8", "units across both buffers", 32'(wrCount - base), 32'd7);
    seqOk = 1;
    for (int k = 0; k < 4; k++)
      if (wrAddr[(base + k) % 512] !== 32'h2000 + 32'(4 * k) ||
          wrData[(base + k) % 512] !== expData(32'h1000 + 32'(4 * k))) seqOk = 0;
    for (int k = 0; k < 3; k++)
      if (wrAddr[(base + 4 + k) % 512] !== 32'h4000 ||
          wrData[(base + 4 + k) % 512] !== expData(32'h3000 + 32'(k))) seqOk = 0;
    check(seqOk, "R3", "chained sequence", 32'(seqOk), 32'd1);
    check(irqCount - irqBase == 2, "R7", "irq per buffer incl. reload",
          32'(irqCount - irqBase), 32'd2);

    // R10 abort
    regWrite(6'h00, 32'h5000); regWrite(6'h0C, 32'h0);
    regWrite(6'h10, ctrlWord(10, 1, 0, 1, 1));
    regWrite(6'h20, 32'h1);
    repeat (3) @(negedge clk);
    regWrite(6'h20, 32'h2);
    repeat (2) @(negedge clk);
    regRead(6'h20, v);
    check(v == 0, "R10", "run and abort clear", v, 32'd0);
    regRead(6'h14, v);
    check(v == 10, "R10", "remaining count kept", v, 32'd10);
    rdBase = rdCount;
    hwForce = 1'b1;
    repeat (10) @(negedge clk);
    hwForce = 1'b0;
    check(rdCount == rdBase, "R10", "no access after abort", 32'(rdCount - rdBase), 32'd0);

    // random runs
    for (int i = 0; i < 15; i++) runRandom(i);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule